// File: doc/BRIEF.md
# SM3 Compression Step Unit

This unit carries out a single step of the SM3 hash compression function on a 128-bit state made of four 32-bit words, numbered 0 (least significant, bits 31:0) to 3 (bits 127:96). A 2-bit opcode selects one of four step flavours. Each flavour picks a boolean mixing function and a finishing stage. A 2-bit word index picks which word of the M operand enters the sum. The surrounding engine provides round constants, message expansion and the sequencing of all 64 rounds. This unit only advances the state by one step per request.

A mode bit turns the unit into a combine operation. That operation rotates the top word of N, adds the top words of M and A with 32-bit wrap-around, and rotates the sum. The result goes into the top output word and the three lower words are cleared.

Requests enter through a valid/ready handshake. The result is registered and appears one cycle after acceptance. It stays on the output until the consumer takes it, and the input is stalled while the output is blocked.

Top module: `sm3_step_unit`

## Requirements
- R1: After synchronous active-high reset, outValid is 0, inReady is 1 and result is all zeros.
- R2: With combineMode=0 and opSel 0 or 2, the mixing value is f = D3 ^ D2 ^ D1 (parity).
- R3: With combineMode=0 and opSel 1, the mixing value is f = (D3&D2)|(D3&D1)|(D2&D1) (majority).
- R4: With combineMode=0 and opSel 3, the mixing value is f = (D3&D2)|(~D3&D1) (choose).
- R5: The step sum is t = f + D0 + M[wordIdx] mod 2^32. Every wordIdx value 0..3 selects the M word with that number.
- R6: For opSel 0 and 1, result word 3 is t + (N3 ^ ror(D3,20)) and result word 1 is ror(D2,23).
- R7: For opSel 2 and 3, u = t + N3 and result word 3 is u ^ rol(u,9) ^ rol(u,17). Result word 1 is ror(D2,13).
- R8: In every step flavour, result word 0 is the old D1 and result word 2 is the old D3.
- R9: With combineMode=1, result word 3 is ror(ror(N3,20) + M3 + A3, 25) using 32-bit wrap-around additions, and words 0 to 2 are zero whatever opSel and wordIdx are.
- R10: A request is taken when inValid && inReady. The result and outValid=1 appear at the next clock edge. outValid and result hold steady while outReady is 0. inReady equals !outValid || outReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Unit can take a request |
| stateIn | input | 128 | State vector D |
| nIn | input | 128 | Operand vector N |
| mIn | input | 128 | Operand vector M |
| aIn | input | 128 | Third operand, used only in combine mode |
| opSel | input | 2 | Step flavour |
| wordIdx | input | 2 | Selects the M word added in the step |
| combineMode | input | 1 | 1 selects the combine operation |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| result | output | 128 | Registered result vector |

## Verification
The bench builds the unit with its default parameters: 32-bit words and four lanes, which are the only sizes the rotation amounts are defined for. With only two 2-bit selectors, every pair of opSel and wordIdx can be swept for each operand pattern. The patterns include all-ones operands that force every modular addition to wrap. Combine mode is run under every opSel to show that the selector has no effect there. A stalled consumer exercises the hold and backpressure behaviour.

// File: rtl/sm3_pkg.sv
package sm3_pkg;
  parameter int WORD_W = 32;
  parameter int LANES  = 4;
  localparam int VEC_W = WORD_W * LANES;
  localparam int IDX_W = $clog2(LANES);

  // rotation amounts of the step and combine paths
  localparam int ROT_D3   = 20;
  localparam int ROT_W1_A = 23;
  localparam int ROT_W1_B = 13;
  localparam int ROL_P1   = 9;
  localparam int ROL_P2   = 17;
  localparam int ROT_N3   = 20;
  localparam int ROT_FIN  = 25;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic load;   // capture a new result this edge
    logic hold;   // result must stay put this edge
  } strobe_t;

  function automatic word_t rotr(word_t x, int unsigned s);
    return (x >> s) | (x << (WORD_W - s));
  endfunction

  function automatic word_t rotl(word_t x, int unsigned s);
    return (x << s) | (x >> (WORD_W - s));
  endfunction
endpackage

// File: rtl/sm3_step_ctrl.sv
module sm3_step_ctrl
  import sm3_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  input  logic    outReady,
  output logic    inReady,
  output logic    outValid,
  output strobe_t strobe
);
  logic validQ;

  assign inReady     = !validQ || outReady;
  assign strobe.load = inValid && inReady;
  assign strobe.hold = validQ && !outReady;
  assign outValid    = validQ;

  always_ff @(posedge clk) begin
    if (rst)              validQ <= 1'b0;
    else if (strobe.load) validQ <= 1'b1;
    else if (outReady)    validQ <= 1'b0;
  end

  // R10: accepted request shows up next edge
  assert_accept_to_valid_R10: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> outValid);
  // R10: blocked output stays valid
  assert_valid_held_R10: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> outValid);
  // R10: backpressure reaches the input
  assert_backpressure_R10: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |-> !inReady);
  // R1: nothing valid right after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !outValid);
endmodule

// File: rtl/sm3_step_datapath.sv
module sm3_step_datapath
  import sm3_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobe,
  input  logic [VEC_W-1:0] stateIn,
  input  logic [VEC_W-1:0] nIn,
  input  logic [VEC_W-1:0] mIn,
  input  logic [VEC_W-1:0] aIn,
  input  logic [1:0]       opSel,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic             combineMode,
  output logic [VEC_W-1:0] result
);
  word_t dW [LANES];
  word_t nW [LANES];
  word_t mW [LANES];
  word_t aW [LANES];

  for (genvar g = 0; g < LANES; g++) begin : gUnpack
    assign dW[g] = stateIn[g*WORD_W +: WORD_W];
    assign nW[g] = nIn[g*WORD_W +: WORD_W];
    assign mW[g] = mIn[g*WORD_W +: WORD_W];
    assign aW[g] = aIn[g*WORD_W +: WORD_W];
  end

  word_t fVal, tSum, uSum, tFin, newW1, combSum, combWord;
  logic [VEC_W-1:0] stepVec, combVec, nextVec;

  // boolean mixing function
  always_comb begin
    unique case (opSel)
      2'd1:    fVal = (dW[3] & dW[2]) | (dW[3] & dW[1]) | (dW[2] & dW[1]);
      2'd3:    fVal = (dW[3] & dW[2]) | (~dW[3] & dW[1]);
      default: fVal = dW[3] ^ dW[2] ^ dW[1];
    endcase
  end

  // sum and finishing stage
  always_comb begin
    tSum = fVal + dW[0] + mW[wordIdx];
    uSum = tSum + nW[3];
    if (!opSel[1]) begin
      tFin  = tSum + (nW[3] ^ rotr(dW[3], ROT_D3));
      newW1 = rotr(dW[2], ROT_W1_A);
    end else begin
      tFin  = uSum ^ rotl(uSum, ROL_P1) ^ rotl(uSum, ROL_P2);
      newW1 = rotr(dW[2], ROT_W1_B);
    end
    stepVec = {tFin, dW[3], newW1, dW[1]};
  end

  // combine operation on the top words
  always_comb begin
    combSum  = rotr(nW[LANES-1], ROT_N3) + mW[LANES-1] + aW[LANES-1];
    combWord = rotr(combSum, ROT_FIN);
    combVec  = '0;
    combVec[VEC_W-1 -: WORD_W] = combWord;
  end

  assign nextVec = combineMode ? combVec : stepVec;

  always_ff @(posedge clk) begin
    if (rst)              result <= '0;
    else if (strobe.load) result <= nextVec;
  end

  // R10: result frozen while the consumer stalls
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (strobe.hold && !strobe.load) |=> $stable(result));
  // R9: combine mode clears the lower words
  assert_combine_low_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && combineMode) |=> (result[VEC_W-WORD_W-1:0] == '0));
  // R8: word shift of the state
  assert_word_shift_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && !combineMode) |=>
      (result[WORD_W-1:0] == $past(stateIn[2*WORD_W-1:WORD_W]) &&
       result[3*WORD_W-1:2*WORD_W] == $past(stateIn[4*WORD_W-1:3*WORD_W])));
endmodule

// File: rtl/sm3_step_unit.sv
module sm3_step_unit
  import sm3_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  output logic               inReady,
  input  logic [VEC_W-1:0]   stateIn,
  input  logic [VEC_W-1:0]   nIn,
  input  logic [VEC_W-1:0]   mIn,
  input  logic [VEC_W-1:0]   aIn,
  input  logic [1:0]         opSel,
  input  logic [IDX_W-1:0]   wordIdx,
  input  logic               combineMode,
  output logic               outValid,
  input  logic               outReady,
  output logic [VEC_W-1:0]   result
);
  strobe_t strobe;

  sm3_step_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  sm3_step_datapath u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .stateIn(stateIn), .nIn(nIn), .mIn(mIn), .aIn(aIn),
    .opSel(opSel), .wordIdx(wordIdx), .combineMode(combineMode),
    .result(result)
  );
endmodule

// File: tb/sm3_step_unit_bench.sv
module sm3_step_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 0, rst = 1;
  logic inValid = 0, outReady = 1, combineMode = 0;
  logic inReady, outValid;
  logic [127:0] stateIn = '0, nIn = '0, mIn = '0, aIn = '0, result;
  logic [1:0] opSel = '0, wordIdx = '0;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm3_step_unit u_sm3_step_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .stateIn(stateIn), .nIn(nIn), .mIn(mIn), .aIn(aIn),
    .opSel(opSel), .wordIdx(wordIdx), .combineMode(combineMode),
    .outValid(outValid), .outReady(outReady), .result(result)
  );

  function automatic logic [31:0] rr(logic [31:0] x, int s);
    return (x >> s) | (x << (32 - s));
  endfunction

  function automatic logic [31:0] wd(logic [127:0] v, int i);
    return v[i*32 +: 32];
  endfunction

  function automatic logic [127:0] model(logic [127:0] d, n, m, a,
                                         int op, int idx, bit mode);
    logic [31:0] f, t, w1;
    if (mode) return {rr(rr(wd(n,3),20) + wd(m,3) + wd(a,3), 25), 96'h0};
    if (op == 1)      f = (wd(d,3)&wd(d,2)) | (wd(d,3)&wd(d,1)) | (wd(d,2)&wd(d,1));
    else if (op == 3) f = (wd(d,3)&wd(d,2)) | (~wd(d,3)&wd(d,1));
    else              f = wd(d,3) ^ wd(d,2) ^ wd(d,1);
    t = f + wd(d,0) + wd(m,idx);
    if (op < 2) begin
      t  = t + (wd(n,3) ^ rr(wd(d,3),20));
      w1 = rr(wd(d,2),23);
    end else begin
      t  = t + wd(n,3);
      t  = t ^ rr(t,23) ^ rr(t,15);   // left by 9 and by 17
      w1 = rr(wd(d,2),13);
    end
    return {t, wd(d,3), w1, wd(d,1)};
  endfunction

  function automatic logic [127:0] rand128();
    logic [127:0] v;
    for (int i = 0; i < 4; i++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      v[i*32 +: 32] = rng;
    end
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOne(logic [127:0] d, n, m, a, int op, int idx, bit mode, string tag);
    logic [127:0] e;
    e = model(d, n, m, a, op, idx, mode);
    @(negedge clk);
    stateIn = d; nIn = n; mIn = m; aIn = a;
    opSel = op[1:0]; wordIdx = idx[1:0]; combineMode = mode; inValid = 1;
    @(posedge clk);
    @(negedge clk);
    inValid = 0;
    check(outValid == 1'b1, {tag, " R10 valid"}, {127'h0, outValid}, 128'h1);
    check(result == e, tag, result, e);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [127:0] d, n, m, a, e1, e2;
    string tags [4];
    tags[0] = "R2 R5 R6 R8";
    tags[1] = "R3 R5 R6 R8";
    tags[2] = "R2 R5 R7 R8";
    tags[3] = "R4 R5 R7 R8";

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    // R1 reset state
    check(outValid == 0, "R1 outValid", {127'h0, outValid}, 128'h0);
    check(inReady == 1, "R1 inReady", {127'h0, inReady}, 128'h1);
    check(result == '0, "R1 result", result, 128'h0);

    // sweep every flavour and index over several operand patterns
    for (int p = 0; p < 5; p++) begin
      if (p == 0) begin d = '1; n = '1; m = '1; a = '1; end   // wrap-around
      else if (p == 1) begin d = '0; n = '0; m = 128'h4444_4444_3333_3333_2222_2222_1111_1111; a = '0; end
      else begin d = rand128(); n = rand128(); m = rand128(); a = rand128(); end
      for (int op = 0; op < 4; op++)
        for (int idx = 0; idx < 4; idx++)
          runOne(d, n, m, a, op, idx, 1'b0, tags[op]);
      // R9: combine mode ignores opSel and wordIdx
      for (int op = 0; op < 4; op++)
        runOne(d, n, m, a, op, 3 - op, 1'b1, "R9 combine");
    end

    // R10: backpressure and hold
    d = rand128(); n = rand128(); m = rand128(); a = rand128();
    e1 = model(d, n, m, a, 1, 2, 1'b0);
    @(negedge clk);
    outReady = 0;
    stateIn = d; nIn = n; mIn = m; aIn = a; opSel = 1; wordIdx = 2; combineMode = 0;
    inValid = 1;
    @(posedge clk);
    @(negedge clk);
    d = rand128(); n = rand128(); m = rand128(); a = rand128();
    e2 = model(d, n, m, a, 2, 0, 1'b1);
    stateIn = d; nIn = n; mIn = m; aIn = a; opSel = 2; wordIdx = 0; combineMode = 1;
    #1;
    check(inReady == 0, "R10 inReady low while stalled", {127'h0, inReady}, 128'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(outValid == 1, "R10 outValid held", {127'h0, outValid}, 128'h1);
      check(result == e1, "R10 result held", result, e1);
    end
    outReady = 1;
    #1;
    check(inReady == 1, "R10 inReady follows outReady", {127'h0, inReady}, 128'h1);
    @(posedge clk);
    @(negedge clk);
    inValid = 0;
    check(result == e2, "R10 R9 second request after release", result, e2);
    @(negedge clk);
    check(outValid == 0, "R10 drained", {127'h0, outValid}, 128'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule